// File: doc/BRIEF.md
# Overlapped Fetch Timing Pulse Sequencer

This block paces a word-serial processor in machine cycles of twelve timing pulses, one pulse per clock. Each cycle is labelled as program time, first operate time, second operate time or a break cycle. In program-time cycles the block itself carries out the instruction fetch. It clears the address register and reads the word at the program counter. It then clears the operation and operand-address registers and loads them from the two halves of the returned word, advancing the counter by one. An instruction's execution starts at pulse 7 and runs into pulses 0 to 6 of the next cycle. The next fetch therefore overlaps the end of the current instruction.

Decode reports how many machine cycles the instruction needs, and the sequencer inserts the operate-time cycles that follow. A long arithmetic step can freeze pulse generation for a fixed count of clocks: a short count for multiply, a long count for divide. An external device can claim one whole machine cycle, at a cycle boundary, to move one word. The program then resumes exactly where it left off.

The memory interface has no back-pressure. The read strobe lasts one clock, during pulse 1, and the address is valid only in that clock. The memory must return the word with a one-clock valid flag before pulse 7 of the same cycle. The last flagged word is the one that loads. A word that never arrives leaves the cleared buffer, so zeros load.

Top module: `pulse_cycle_ctrl`

## Requirements
- R1: While reset is asserted the pulse number is 0, pulses are live, the cycle type is program time (code 0), and the program counter, address register, operation and operand-address registers are zero.
- R2: While no pause is active, the pulse number advances by one every clock from 0 to 11 and then wraps to 0.
- R3: In program time, pulse 0 asserts the address-clear strobe, after which the address register reads zero. Pulse 1 asserts the read strobe with the program counter on the address port. The address register then holds that counter value, and the read buffer is cleared.
- R4: In program time, pulse 6 asserts the register-clear strobe, after which the operation and operand-address registers read zero. Pulse 7 asserts the load strobe, after which the program counter is one higher.
- R5: At pulse 7, the operation register takes bits 31..16 of the last word flagged valid by memory, and the operand-address register takes bits 15..0.
- R6: The cycle-type code is 0 for program time, 1 for operate A, 2 for operate B and 3 for break. The length input is sampled when a program-time cycle ends. A length of 0 or 1 is followed by program time, 2 by operate A then program time, and 3 by operate A, operate B, then program time. The cycle type changes only when pulse 11 ends.
- R7: Fetch strobes appear only in program-time cycles, and at most one is active in any clock.
- R8: A pause request during a live pulse k (select low = 32 clocks, select high = 104 clocks) hides that many clocks. During them the pulse-valid output is low, no strobe fires and no register changes. Pulse k+1 follows.
- R9: A break request that is high when pulse 11 ends inserts one break cycle of twelve pulses. That cycle has no fetch strobes. It is followed by the cycle type that would otherwise have come next.
- R10: A break request held across a pause that begins at pulse 11 takes effect when the pause ends: the first visible pulse is pulse 0 of a break cycle.
- R11: The program counter wraps from its largest value to zero.
- R12: A pause request made during a break cycle is ignored, and the next pulse follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse clock, one timing pulse per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_len_i | input | 2 | Machine cycles required by the current instruction, from decode |
| pause_req_i | input | 1 | Request for an arithmetic pause, one clock |
| pause_div_i | input | 1 | Pause length select: 0 short (multiply), 1 long (divide) |
| brk_req_i | input | 1 | Device request for a break cycle, held until the break starts |
| mem_rvalid_i | input | 1 | Read data valid flag from memory |
| mem_rdata_i | input | DW | Read data word from memory |
| mem_rd_o | output | 1 | Read strobe, pulse 1 of program time |
| mem_addr_o | output | AW | Read address, valid with the read strobe |
| tp_o | output | 4 | Current timing pulse number |
| tp_valid_o | output | 1 | High when a pulse is live (no pause) |
| cyc_o | output | 2 | Current machine cycle type |
| mar_clr_o | output | 1 | Address-register clear strobe |
| reg_clr_o | output | 1 | Operation and operand-address clear strobe |
| load_o | output | 1 | Instruction load and counter advance strobe |
| pc_o | output | AW | Program counter |
| mar_o | output | AW | Memory address register |
| op_o | output | DW/2 | Operation register |
| oa_o | output | DW/2 | Operand-address register |

## Verification
Two of the block's functions can meet at pulse 11, where the break decision and an arithmetic pause compete for the same clock edge. The bench raises a pause request and a break request together during pulse 11. It then checks that the cycle type stays unchanged throughout the hidden clocks, and that the first visible pulse is pulse 0 of a break cycle. It also places a pause request in the middle of a break cycle and checks that the next pulse still arrives on the next clock. The bench judges both cases clock by clock against a behavioural model of the pulse count, the cycle order and the fetch registers.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // twelve pulses per machine cycle
  localparam int unsigned TP_COUNT = 12;
  localparam int unsigned TP_W     = $clog2(TP_COUNT);
  localparam logic [TP_W-1:0] TP_LAST = TP_W'(TP_COUNT - 1);

  // fetch pulses inside a program-time cycle; execution starts at TP_LOAD
  localparam logic [TP_W-1:0] TP_ADDR_CLR = TP_W'(0);
  localparam logic [TP_W-1:0] TP_READ     = TP_W'(1);
  localparam logic [TP_W-1:0] TP_REG_CLR  = TP_W'(6);
  localparam logic [TP_W-1:0] TP_LOAD     = TP_W'(7);

  typedef enum logic [1:0] {
    CYC_PT  = 2'd0,
    CYC_OTA = 2'd1,
    CYC_OTB = 2'd2,
    CYC_BRK = 2'd3
  } cyc_e;

  typedef struct packed {
    logic addr_clr;
    logic read;
    logic reg_clr;
    logic load;
  } fetch_cmd_t;

endpackage

// File: rtl/tps_pulse_ring.sv
module tps_pulse_ring
  import tps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  output logic [TP_W-1:0] tp_o,
  output logic            wrap_o
);

  logic [TP_W-1:0] tp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tp_q <= '0;
    else if (step_i) tp_q <= (tp_q == TP_LAST) ? '0 : tp_q + TP_W'(1);
  end

  assign tp_o   = tp_q;
  assign wrap_o = step_i && (tp_q == TP_LAST);

  // R2
  tp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_q <= TP_LAST);

  // R2
  tp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && tp_q != TP_LAST) |=> tp_q == $past(tp_q) + TP_W'(1));

  // R8
  tp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(tp_q));

endmodule

// File: rtl/tps_pause_timer.sv
module tps_pause_timer #(
  parameter int unsigned MUL_N = 32,
  parameter int unsigned DIV_N = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic div_i,
  input  logic allow_i,
  output logic live_o,
  output logic step_o
);

  localparam int unsigned MAX_N = (DIV_N > MUL_N) ? DIV_N : MUL_N;
  localparam int unsigned CW    = $clog2(MAX_N + 1);

  logic [CW-1:0] cnt_q;
  logic          idle;
  logic          accept;

  assign idle   = (cnt_q == '0);
  assign accept = idle && req_i && allow_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (accept) cnt_q <= div_i ? CW'(DIV_N) : CW'(MUL_N);
    else if (!idle)  cnt_q <= cnt_q - CW'(1);
  end

  assign live_o = idle;
  // the pulse counter steps on a free live clock, or on the last hidden clock
  assign step_o = (idle && !accept) || (cnt_q == CW'(1));

  // R8
  pause_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));

  // R8
  pause_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o && !step_o) |=> !live_o);

endmodule

// File: rtl/tps_cycle_seq.sv
module tps_cycle_seq
  import tps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap_i,
  input  logic [1:0] len_i,
  input  logic       brk_req_i,
  output cyc_e       cyc_o
);

  cyc_e       cyc_q;
  cyc_e       resume_q;
  cyc_e       next_norm;
  logic [1:0] len_q;

  always_comb begin
    unique case (cyc_q)
      CYC_PT:  next_norm = (len_i >= 2'd2) ? CYC_OTA : CYC_PT;
      CYC_OTA: next_norm = (len_q == 2'd3) ? CYC_OTB : CYC_PT;
      CYC_OTB: next_norm = CYC_PT;
      default: next_norm = resume_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CYC_PT;
      resume_q <= CYC_PT;
      len_q    <= 2'd1;
    end else if (wrap_i) begin
      if (cyc_q == CYC_PT) len_q <= len_i;
      if (brk_req_i) begin
        cyc_q    <= CYC_BRK;
        resume_q <= next_norm;
      end else begin
        cyc_q    <= next_norm;
      end
    end
  end

  assign cyc_o = cyc_q;

  // R6
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(cyc_q));

  // R6
  otb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_OTB) |-> (len_q == 2'd3));

  // R9
  brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && cyc_q == CYC_BRK && !brk_req_i) |=> cyc_q != CYC_BRK);

endmodule

// File: rtl/tps_fetch_regs.sv
module tps_fetch_regs
  import tps_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fetch_cmd_t    cmd_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mar_o,
  output logic [DW/2-1:0] op_o,
  output logic [DW/2-1:0] oa_o
);

  localparam int unsigned HW = DW / 2;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mbr_q;
  logic [HW-1:0] op_q;
  logic [HW-1:0] oa_q;

  // read buffer: cleared when the read starts, a flagged word overrides
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mbr_q <= '0;
    else if (rvalid_i)   mbr_q <= rdata_i;
    else if (cmd_i.read) mbr_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mar_q <= '0;
    else if (cmd_i.addr_clr) mar_q <= '0;
    else if (cmd_i.read)     mar_q <= pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      oa_q <= '0;
    end else if (cmd_i.reg_clr) begin
      op_q <= '0;
      oa_q <= '0;
    end else if (cmd_i.load) begin
      op_q <= mbr_q[DW-1:HW];
      oa_q <= mbr_q[HW-1:0];
    end
  end

  // counter wraps naturally at the top of its range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (cmd_i.load) pc_q <= pc_q + AW'(1);
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign op_o  = op_q;
  assign oa_o  = oa_q;

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.load |=> pc_q == $past(pc_q) + AW'(1));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i.load |=> $stable(pc_q));

  // R4
  reg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.reg_clr |=> (op_q == '0) && (oa_q == '0));

  // R3
  mar_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.read |=> mar_q == $past(pc_q));

endmodule

// File: rtl/pulse_cycle_ctrl.sv
module pulse_cycle_ctrl
  import tps_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned MUL_PAUSE = 32,
  parameter int unsigned DIV_PAUSE = 104
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_len_i,
  input  logic            pause_req_i,
  input  logic            pause_div_i,
  input  logic            brk_req_i,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [TP_W-1:0] tp_o,
  output logic            tp_valid_o,
  output logic [1:0]      cyc_o,
  output logic            mar_clr_o,
  output logic            reg_clr_o,
  output logic            load_o,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   mar_o,
  output logic [DW/2-1:0] op_o,
  output logic [DW/2-1:0] oa_o
);

  logic            live;
  logic            step;
  logic            wrap;
  logic [TP_W-1:0] tp;
  cyc_e            cyc;
  logic            fetch_en;
  fetch_cmd_t      cmd;

  tps_pause_timer #(
    .MUL_N (MUL_PAUSE),
    .DIV_N (DIV_PAUSE)
  ) i_pause (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pause_req_i),
    .div_i   (pause_div_i),
    .allow_i (cyc != CYC_BRK),
    .live_o  (live),
    .step_o  (step)
  );

  tps_pulse_ring i_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .tp_o   (tp),
    .wrap_o (wrap)
  );

  tps_cycle_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_i    (wrap),
    .len_i     (ext_len_i),
    .brk_req_i (brk_req_i),
    .cyc_o     (cyc)
  );

  // fetch commands decode only on live program-time pulses
  assign fetch_en = live && (cyc == CYC_PT);

  always_comb begin
    cmd          = '0;
    cmd.addr_clr = fetch_en && (tp == TP_ADDR_CLR);
    cmd.read     = fetch_en && (tp == TP_READ);
    cmd.reg_clr  = fetch_en && (tp == TP_REG_CLR);
    cmd.load     = fetch_en && (tp == TP_LOAD);
  end

  tps_fetch_regs #(
    .AW (AW),
    .DW (DW)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .rvalid_i (mem_rvalid_i),
    .rdata_i  (mem_rdata_i),
    .pc_o     (pc_o),
    .mar_o    (mar_o),
    .op_o     (op_o),
    .oa_o     (oa_o)
  );

  assign mem_rd_o   = cmd.read;
  assign mem_addr_o = pc_o;
  assign tp_o       = tp;
  assign tp_valid_o = live;
  assign cyc_o      = cyc;
  assign mar_clr_o  = cmd.addr_clr;
  assign reg_clr_o  = cmd.reg_clr;
  assign load_o     = cmd.load;

  // R7
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  // R7
  cmd_pt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != '0) |-> (cyc_o == 2'd0));

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_valid_o |-> (cmd == '0));

  // R12
  brk_no_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_valid_o && cyc_o == 2'd3) |=> tp_valid_o);

endmodule

// File: tb/test_pulse_cycle_ctrl.sv
module test_pulse_cycle_ctrl;

  localparam int AW     = 8;
  localparam int DW     = 32;
  localparam int PC_MOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ext_len_i = 2'd1;
  logic          pause_req_i = 1'b0;
  logic          pause_div_i = 1'b0;
  logic          brk_req_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [3:0]    tp_o;
  logic          tp_valid_o;
  logic [1:0]    cyc_o;
  logic          mar_clr_o, reg_clr_o, load_o;
  logic [AW-1:0] pc_o, mar_o;
  logic [15:0]   op_o, oa_o;

  int checks = 0;
  int errors = 0;
  bit timeout = 0;

  always #10 clk = ~clk;

  pulse_cycle_ctrl #(.AW(AW), .DW(DW)) i_pulse_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_len_i(ext_len_i), .pause_req_i(pause_req_i),
    .pause_div_i(pause_div_i), .brk_req_i(brk_req_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .tp_o(tp_o), .tp_valid_o(tp_valid_o), .cyc_o(cyc_o), .mar_clr_o(mar_clr_o),
    .reg_clr_o(reg_clr_o), .load_o(load_o), .pc_o(pc_o), .mar_o(mar_o),
    .op_o(op_o), .oa_o(oa_o)
  );

  function automatic logic [31:0] mem_word(int a);
    return {16'((a * 37 + 165) & 16'hffff), 16'(a ^ 16'h5a5a)};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_tp = 0, m_cyc = 0, m_resume = 0, m_len = 1, m_cnt = 0;
  int m_pc = 0, m_mar = 0, m_op = 0, m_oa = 0, m_nxt = 0;
  logic [31:0] m_mbr = '0, m_old = '0;
  bit m_live, m_acc, m_fe, m_adv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tp = 0; m_cyc = 0; m_resume = 0; m_len = 1; m_cnt = 0;
      m_pc = 0; m_mar = 0; m_op = 0; m_oa = 0; m_mbr = '0;
    end else begin
      m_live = (m_cnt == 0);
      m_acc  = m_live && pause_req_i && (m_cyc != 3);
      m_fe   = m_live && (m_cyc == 0);
      m_old  = m_mbr;
      if (m_fe) begin
        if (m_tp == 0) m_mar = 0;
        if (m_tp == 1) begin m_mar = m_pc; m_mbr = '0; end
        if (m_tp == 6) begin m_op = 0; m_oa = 0; end
        if (m_tp == 7) begin
          m_op = int'(m_old[31:16]); m_oa = int'(m_old[15:0]);
          m_pc = (m_pc + 1) % PC_MOD;
        end
      end
      if (mem_rvalid_i) m_mbr = mem_rdata_i;
      m_adv = 0;
      if (m_acc) m_cnt = pause_div_i ? 104 : 32;
      else if (m_cnt == 1) begin m_cnt = 0; m_adv = 1; end
      else if (m_cnt > 1) m_cnt = m_cnt - 1;
      else m_adv = 1;
      if (m_adv) begin
        if (m_tp == 11) begin
          m_tp = 0;
          case (m_cyc)
            0: begin m_len = int'(ext_len_i); m_nxt = (m_len >= 2) ? 1 : 0; end
            1: m_nxt = (m_len == 3) ? 2 : 0;
            2: m_nxt = 0;
            default: m_nxt = m_resume;
          endcase
          if (brk_req_i) begin m_resume = m_nxt; m_cyc = 3; end
          else m_cyc = m_nxt;
        end else begin
          m_tp = m_tp + 1;
        end
      end
    end
  end

  // memory: answers four pulses after the read, during pulse 5
  always @(negedge clk) begin
    mem_rvalid_i = rst_n && (m_cnt == 0) && (m_cyc == 0) && (m_tp == 5);
    mem_rdata_i  = mem_word(m_mar);
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit pt;
      pt = (m_cnt == 0) && (m_cyc == 0);
      chk("R2 pulse number", tp_o, m_tp);
      chk("R8 pulse valid", tp_valid_o, m_cnt == 0);
      chk("R6 cycle type", cyc_o, m_cyc);
      chk("R3 address register", mar_o, m_mar);
      chk("R4 program counter", pc_o, m_pc);
      chk("R5 operation register", op_o, m_op);
      chk("R5 operand-address register", oa_o, m_oa);
      chk("R7 strobes", {mar_clr_o, mem_rd_o, reg_clr_o, load_o},
          {pt && m_tp == 0, pt && m_tp == 1, pt && m_tp == 6, pt && m_tp == 7});
      if (mem_rd_o) chk("R3 read address", mem_addr_o, m_pc);
    end
  end

  task automatic wait_for(int c, int t);
    do @(negedge clk); while (!(m_cnt == 0 && m_cyc == c && m_tp == t));
  endtask

  task automatic pause_at(int c, int t, bit dv, int exp_n);
    int hidden = 0;
    wait_for(c, t);
    pause_req_i = 1'b1; pause_div_i = dv;
    @(negedge clk);
    pause_req_i = 1'b0;
    while (!tp_valid_o && hidden < 1000) begin hidden++; @(negedge clk); end
    chk("R8 hidden clocks", hidden, exp_n);
    chk("R8 resumed pulse", tp_o, (t + 1) % 12);
  endtask

  task automatic run_all();
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pulse", tp_o, 0);
    chk("R1 valid", tp_valid_o, 1);
    chk("R1 cycle", cyc_o, 0);
    chk("R1 counter", pc_o, 0);
    chk("R1 registers", {mar_o, op_o, oa_o}, 0);
    rst_n = 1'b1;

    ext_len_i = 2'd1; repeat (60) @(negedge clk);
    ext_len_i = 2'd2; repeat (72) @(negedge clk);
    ext_len_i = 2'd3; repeat (96) @(negedge clk);
    ext_len_i = 2'd0; repeat (36) @(negedge clk);

    // R8 multiply pause during a fetch, divide pause during operate A
    pause_at(0, 3, 1'b0, 32);
    ext_len_i = 2'd3;
    pause_at(1, 8, 1'b1, 104);

    // R10 pause and break meeting at pulse 11
    wait_for(2, 11);
    pause_req_i = 1'b1; pause_div_i = 1'b0; brk_req_i = 1'b1;
    @(negedge clk);
    pause_req_i = 1'b0;
    chk("R10 cycle held while paused", cyc_o, 2);
    while (!tp_valid_o) @(negedge clk);
    chk("R10 break after pause", cyc_o, 3);
    chk("R10 break starts at pulse 0", tp_o, 0);
    brk_req_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 program time resumes", cyc_o, 0);

    // R9 break between operate A and operate B, R12 pause inside it
    ext_len_i = 2'd3;
    wait_for(1, 11);
    brk_req_i = 1'b1;
    @(negedge clk);
    brk_req_i = 1'b0;
    chk("R9 break cycle", cyc_o, 3);
    repeat (3) @(negedge clk);
    pause_req_i = 1'b1;
    @(negedge clk);
    pause_req_i = 1'b0;
    chk("R12 pause ignored in break", tp_valid_o, 1);
    chk("R12 pulse continues", tp_o, 4);
    repeat (8) @(negedge clk);
    chk("R9 operate B follows break", cyc_o, 2);
    chk("R9 pulse 0 after break", tp_o, 0);

    // R11 counter wrap
    ext_len_i = 2'd1;
    begin
      int guard = 0;
      while (pc_o != AW'(PC_MOD - 1) && guard < 20000) begin guard++; @(negedge clk); end
      while (!load_o && guard < 20000) begin guard++; @(negedge clk); end
      @(negedge clk);
      chk("R11 counter wraps", pc_o, 0);
    end
    repeat (24) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule